// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer

This block is a small direct-mapped cache that the fetch stage searches on every fetch address. It does not wait for decode to say whether the word is a branch. Each entry pairs an address tag with the next PC seen the last time that branch was taken. On a hit, the block returns the stored target, so fetch can redirect in the same cycle at no added cost. On a miss, it returns the sequential address, PC+4.

When execute resolves a branch, it reports the branch PC, the computed target and whether the branch was taken. A taken branch writes its entry, replacing whatever held that slot. A not-taken branch never allocates an entry. If a not-taken branch matches a live entry, that entry is invalidated. As with any cache, more entries give fewer misses. The default holds 16 entries, indexed by PC[5:2], and the remaining upper PC bits form the tag.

Top module: `fetch_btb`

## Requirements
- R1: After reset, no entry is valid, so every lookup returns pred_hit=0.
- R2: An update with upd_valid=1 and upd_taken=1 takes effect at the next rising edge. From then on, a lookup of that same PC returns pred_hit=1 and pred_target equal to the written target.
- R3: On a miss, pred_target equals fetch_pc+4. Fetch and update PCs are word aligned, with bits [1:0] equal to zero.
- R4: A lookup whose PC shares an entry's index (PC[5:2]) but differs in any bit of PC[31:6] misses.
- R5: Entries at different indices are independent. A taken update at an occupied index with a different tag replaces the old entry, and the old PC then misses.
- R6: A not-taken update whose PC matches a valid entry clears that entry, so the PC then misses.
- R7: A not-taken update never allocates an entry. If its PC does not match the entry at its index, the stored entry is left unchanged.
- R8: If a lookup and an update hit the same index in one cycle, the lookup returns the contents held before the update.
- R9: While upd_valid=0, the other update inputs have no effect on the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset that clears all valid bits |
| fetch_pc | input | ADDR_W | Current fetch address |
| pred_hit | output | 1 | The lookup matched a valid entry |
| pred_target | output | ADDR_W | Predicted next PC: stored target on a hit, fetch_pc+4 on a miss |
| upd_valid | input | 1 | A resolved branch is being reported this cycle |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_target | input | ADDR_W | Target computed by execute |
| upd_taken | input | 1 | The resolved branch was taken |

## Verification
The hardest situation to create is a lookup and an update that collide on the same index in the same cycle. In that case the combinational read must still see the pre-edge contents. The bench creates the collision by setting fetch_pc and the update fields together at the falling edge, then sampling the outputs before the rising edge. It does this once on an empty slot and once on a live slot that is being overwritten. It then reads the new contents in the following cycle. Clearing on a not-taken update is checked against both a matching tag and an aliasing tag at the same index.

// File: rtl/fetch_btb.sv
module fetch_btb #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              pred_hit,
  output logic [ADDR_W-1:0] pred_target,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic              upd_taken
);
  localparam int LO    = 2;
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - IDX_W - LO;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ADDR_W-1:0]  tgt_q [ENTRIES];

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [TAG_W-1:0] rd_tag, wr_tag;
  logic             wr_match;

  assign rd_idx = fetch_pc[IDX_W+LO-1:LO];
  assign rd_tag = fetch_pc[ADDR_W-1:IDX_W+LO];
  assign wr_idx = upd_pc[IDX_W+LO-1:LO];
  assign wr_tag = upd_pc[ADDR_W-1:IDX_W+LO];

  assign pred_hit    = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign pred_target = pred_hit ? tgt_q[rd_idx] : fetch_pc + ADDR_W'(4);
  assign wr_match    = valid_q[wr_idx] && (tag_q[wr_idx] == wr_tag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      valid_q <= '0;
    else if (upd_valid) begin
      if (upd_taken)
        valid_q[wr_idx] <= 1'b1;
      else if (wr_match)
        valid_q[wr_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_valid && upd_taken) begin
      tag_q[wr_idx] <= wr_tag;
      tgt_q[wr_idx] <= upd_target;
    end
  end

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !pred_hit); // R1

  AST_ALLOC_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken) |=>
      ((fetch_pc[ADDR_W-1:LO] != $past(upd_pc[ADDR_W-1:LO])) ||
       (pred_hit && pred_target == $past(upd_target)))); // R2

  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_pc[LO-1:0] == '0) && (!upd_valid || upd_pc[LO-1:0] == '0)); // R3

  AST_NT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken) |=>
      !(pred_hit && fetch_pc[ADDR_W-1:LO] == $past(upd_pc[ADDR_W-1:LO]))); // R6

  AST_NT_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken) |=> $countones(valid_q) <= $countones($past(valid_q))); // R7

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(valid_q)); // R9
endmodule

// File: tb/fetch_btb_bench.sv
module fetch_btb_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        pred_hit;
  logic [31:0] pred_target;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic [31:0] upd_target = '0;
  logic        upd_taken = 1'b0;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fetch_btb u_fetch_btb (
    .clk, .rst_n, .fetch_pc, .pred_hit, .pred_target,
    .upd_valid, .upd_pc, .upd_target, .upd_taken
  );

  task automatic check(string req, logic exp_hit, logic [31:0] exp_tgt);
    n_checks++;
    if (pred_hit !== exp_hit || pred_target !== exp_tgt) begin
      n_fail++;
      $display("FAIL %s pc=%h: hit=%0b target=%h, expected hit=%0b target=%h",
               req, fetch_pc, pred_hit, pred_target, exp_hit, exp_tgt);
    end
  endtask

  task automatic look(string req, logic [31:0] pc, logic exp_hit, logic [31:0] exp_tgt);
    fetch_pc = pc;
    #1;
    check(req, exp_hit, exp_hit ? exp_tgt : pc + 32'd4);
  endtask

  task automatic update(logic [31:0] pc, logic [31:0] tgt, logic taken);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_target = tgt; upd_taken = taken;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic t_reset;
    look("R1", 32'h0000_0000, 0, '0);
    look("R1", 32'h1000_0040, 0, '0);
    look("R3", 32'hFFFF_FFFC, 0, '0);
  endtask

  task automatic t_alloc;
    update(32'h1000_0040, 32'h0000_2000, 1);
    look("R2", 32'h1000_0040, 1, 32'h0000_2000);
  endtask

  task automatic t_tag;
    look("R4", 32'h1000_0080, 0, '0);
    look("R4", 32'h9000_0040, 0, '0);
  endtask

  task automatic t_index;
    update(32'h0000_0104, 32'h0000_0300, 1);
    update(32'h0000_0108, 32'h0000_0400, 1);
    look("R5", 32'h0000_0104, 1, 32'h0000_0300);
    look("R5", 32'h0000_0108, 1, 32'h0000_0400);
    look("R5", 32'h1000_0040, 1, 32'h0000_2000);
    update(32'h1000_0080, 32'h0000_5000, 1);
    look("R5", 32'h1000_0080, 1, 32'h0000_5000);
    look("R5", 32'h1000_0040, 0, '0);
  endtask

  task automatic t_nt_clear;
    update(32'h0000_0104, 32'h0000_0108, 0);
    look("R6", 32'h0000_0104, 0, '0);
    look("R6", 32'h0000_0108, 1, 32'h0000_0400);
  endtask

  task automatic t_nt_noalloc;
    update(32'h2000_0108, 32'h0000_0AAA, 0);
    look("R7", 32'h0000_0108, 1, 32'h0000_0400);
    look("R7", 32'h2000_0108, 0, '0);
    update(32'h0000_010C, 32'h0000_0BBB, 0);
    look("R7", 32'h0000_010C, 0, '0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    fetch_pc = 32'h0000_0110;
    upd_valid = 1'b1; upd_pc = 32'h0000_0110; upd_target = 32'h0000_0777; upd_taken = 1'b1;
    #1;
    check("R8", 0, 32'h0000_0114);
    @(negedge clk);
    upd_valid = 1'b0;
    look("R8", 32'h0000_0110, 1, 32'h0000_0777);
    @(negedge clk);
    fetch_pc = 32'h0000_0108;
    upd_valid = 1'b1; upd_pc = 32'h0000_0108; upd_target = 32'h0000_0999; upd_taken = 1'b1;
    #1;
    check("R8", 1, 32'h0000_0400);
    @(negedge clk);
    upd_valid = 1'b0;
    look("R8", 32'h0000_0108, 1, 32'h0000_0999);
  endtask

  task automatic t_idle;
    @(negedge clk);
    upd_valid = 1'b0; upd_pc = 32'h0000_0114; upd_target = 32'h0000_0CCC; upd_taken = 1'b1;
    repeat (3) @(negedge clk);
    upd_pc = 32'h0000_0108; upd_taken = 1'b0;
    repeat (3) @(negedge clk);
    look("R9", 32'h0000_0114, 0, '0);
    look("R9", 32'h0000_0108, 1, 32'h0000_0999);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_alloc;
    t_tag;
    t_index;
    t_nt_clear;
    t_nt_noalloc;
    t_same_cycle;
    t_idle;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule